// File: doc/BRIEF.md
# Masked Prioritized Interrupt Controller

The controller takes 64 level-sensitive request inputs. Slot 0 is reserved and never requests, so 63 slots are usable sources. Each slot has a mask bit and a control byte. The control byte gives the slot an interrupt level and a priority inside that level. Every cycle the controller picks, from the slots that are requesting, unmasked and configured, the one with the highest level. Ties go to the higher priority and then to the lower slot number. It presents the winner to the processor as a 3-bit level and a 6-bit slot number.

Software reaches the mask bits and the control bytes through a byte-wide register port. Mask bit 0 is not a source mask. It is a global switch that blocks every slot. Because of this, writing the single value 1 into the low mask register silences the whole controller. Both output fields are registered.

Top module: `mpic_top`

## Requirements
- R1: Register port, with the byte address `bus_addr[6:0]`. When bit 6 is 1, the access targets the control byte of slot `bus_addr[5:0]`. When bit 6 is 0, `bus_addr[2:0]` selects byte b of the 64-bit mask vector, and bit k of that byte is the mask of slot 8*b+k. Bytes 0 to 3 form the low mask register (slots 0 to 31) and bytes 4 to 7 form the high mask register (slots 32 to 63). A write takes effect at the clock edge where `bus_wr` is 1. `bus_rdata` returns the stored byte at the address presented in the previous cycle.
- R2: After reset every mask bit is 1, every control byte is 0, and `irq_level` and `irq_vec` are 0.
- R3: While mask bit 0 is 1, no slot is presented, whatever its own mask bit holds. Writing 0x01 to mask byte 0 therefore blocks everything.
- R4: A slot whose mask bit is 1 is never presented, and clearing the bit lets it compete. Slot 0 is never presented.
- R5: In a control byte, bits 5:3 hold the level and bits 2:0 hold the priority. A slot whose level field is 0 is never presented. This includes an all-zero, unconfigured byte.
- R6: Among eligible slots, the one with the highest level wins.
- R7: Among eligible slots of equal level, the one with the highest priority field wins.
- R8: Among eligible slots with equal level and equal priority, the lowest slot number wins.
- R9: `irq_level`/`irq_vec` show the winner for the inputs and register state of the previous cycle. When no slot is eligible, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 64 | Level request per slot (bit 0 ignored) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| irq_level | output | 3 | Level of the winning slot, 0 for none |
| irq_vec | output | 6 | Number of the winning slot, 0 for none |

## Verification
Some rules are checked by assertions on every cycle. The global mask must silence the outputs one cycle later. Slot 0 and a zero vector must never appear beside a nonzero level. The arbiter's winner must never be a masked slot or one with a zero level field. A control write must land in the addressed byte. Which slot wins under competing level, priority and slot number can only be shown by the bench's scenarios, which compare against an independent model. The same holds for read-back through the byte map, and for a slot returning after its mask is cleared.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int SLOT_N = 64;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/mpic_regs.sv
module mpic_regs #(
  parameter int SLOT_N = mpic_pkg::SLOT_N,
  parameter int BYTE_W = mpic_pkg::BYTE_W,
  localparam int IDX_W = $clog2(SLOT_N),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  output logic [SLOT_N-1:0]        mask_o,
  output logic [SLOT_N*BYTE_W-1:0] ctrl_o
);
  localparam int MASK_BYTES = SLOT_N / BYTE_W;
  localparam int BSEL_W     = $clog2(MASK_BYTES);

  logic [SLOT_N-1:0] mask_q;
  logic [BYTE_W-1:0] ctrl_q [SLOT_N];
  logic [BYTE_W-1:0] rdata_q;

  logic              is_ctrl;
  logic              mask_hit;
  logic [IDX_W-1:0]  slot;
  logic [BSEL_W-1:0] bsel;

  assign is_ctrl  = addr[ADDR_W-1];
  assign slot     = addr[IDX_W-1:0];
  assign bsel     = addr[BSEL_W-1:0];
  assign mask_hit = !is_ctrl && (addr[IDX_W-1:BSEL_W] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      rdata_q <= '0;
      for (int i = 0; i < SLOT_N; i++) ctrl_q[i] <= '0;
    end else begin
      if (wr_en) begin
        if (is_ctrl) ctrl_q[slot] <= wdata;
        else if (mask_hit) mask_q[bsel*BYTE_W +: BYTE_W] <= wdata;
      end
      if (is_ctrl) rdata_q <= ctrl_q[slot];
      else if (mask_hit) rdata_q <= mask_q[bsel*BYTE_W +: BYTE_W];
      else rdata_q <= '0;
    end
  end

  assign rdata  = rdata_q;
  assign mask_o = mask_q;

  for (genvar g = 0; g < SLOT_N; g++) begin : g_flat
    assign ctrl_o[g*BYTE_W +: BYTE_W] = ctrl_q[g];
  end

  // R1: a control write lands in the addressed byte
  a_r1_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_ctrl) |=> (ctrl_q[$past(slot)] == $past(wdata)));

  // R1: a mask write lands in the addressed byte lane
  a_r1_mask_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mask_hit) |=> (mask_q[$past(bsel)*BYTE_W +: BYTE_W] == $past(wdata)));
endmodule

// File: rtl/mpic_elig.sv
module mpic_elig #(
  parameter int SLOT_N = mpic_pkg::SLOT_N,
  parameter int BYTE_W = mpic_pkg::BYTE_W,
  parameter int LVL_W  = mpic_pkg::LVL_W,
  parameter int PRI_W  = mpic_pkg::PRI_W,
  localparam int KEY_W = LVL_W + PRI_W
) (
  input  logic [SLOT_N-1:0]        src,
  input  logic [SLOT_N-1:0]        mask,
  input  logic [SLOT_N*BYTE_W-1:0] ctrl,
  output logic [SLOT_N-1:0]        elig,
  output logic [SLOT_N*KEY_W-1:0]  key
);
  logic block_all;
  assign block_all = mask[0];

  assign elig[0] = 1'b0;
  assign key[KEY_W-1:0] = '0;

  for (genvar g = 1; g < SLOT_N; g++) begin : g_slot
    logic [BYTE_W-1:0] cb;
    logic              lvl_set;
    assign cb      = ctrl[g*BYTE_W +: BYTE_W];
    assign lvl_set = (cb[KEY_W-1:PRI_W] != '0);
    assign elig[g] = src[g] && !mask[g] && !block_all && lvl_set;
    assign key[g*KEY_W +: KEY_W] = cb[KEY_W-1:0];
  end
endmodule

// File: rtl/mpic_arb.sv
module mpic_arb #(
  parameter int SLOT_N = mpic_pkg::SLOT_N,
  parameter int KEY_W  = mpic_pkg::LVL_W + mpic_pkg::PRI_W,
  localparam int IDX_W = $clog2(SLOT_N),
  localparam int NODES = 2*SLOT_N - 1
) (
  input  logic [SLOT_N-1:0]       elig,
  input  logic [SLOT_N*KEY_W-1:0] key,
  output logic                    win_vld,
  output logic [KEY_W-1:0]        win_key,
  output logic [IDX_W-1:0]        win_idx
);
  logic             n_vld [NODES];
  logic [KEY_W-1:0] n_key [NODES];
  logic [IDX_W-1:0] n_idx [NODES];

  for (genvar i = 0; i < SLOT_N; i++) begin : g_leaf
    assign n_vld[SLOT_N-1+i] = elig[i];
    assign n_key[SLOT_N-1+i] = key[i*KEY_W +: KEY_W];
    assign n_idx[SLOT_N-1+i] = IDX_W'(i);
  end

  // left child always covers the lower slot numbers; ties stay left
  for (genvar n = 0; n < SLOT_N-1; n++) begin : g_node
    logic take_r;
    assign take_r = n_vld[2*n+2] &&
                    (!n_vld[2*n+1] || (n_key[2*n+2] > n_key[2*n+1]));
    assign n_vld[n] = n_vld[2*n+1] || n_vld[2*n+2];
    assign n_key[n] = take_r ? n_key[2*n+2] : n_key[2*n+1];
    assign n_idx[n] = take_r ? n_idx[2*n+2] : n_idx[2*n+1];
  end

  assign win_vld = n_vld[0];
  assign win_key = n_key[0];
  assign win_idx = n_idx[0];
endmodule

// File: rtl/mpic_top.sv
module mpic_top #(
  parameter int SLOT_N = mpic_pkg::SLOT_N,
  parameter int BYTE_W = mpic_pkg::BYTE_W,
  parameter int LVL_W  = mpic_pkg::LVL_W,
  parameter int PRI_W  = mpic_pkg::PRI_W,
  localparam int IDX_W  = $clog2(SLOT_N),
  localparam int ADDR_W = IDX_W + 1,
  localparam int KEY_W  = LVL_W + PRI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_N-1:0] irq_src,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [LVL_W-1:0]  irq_level,
  output logic [IDX_W-1:0]  irq_vec
);
  logic [SLOT_N-1:0]        mask_w;
  logic [SLOT_N*BYTE_W-1:0] ctrl_w;
  logic [SLOT_N-1:0]        elig_w;
  logic [SLOT_N*KEY_W-1:0]  key_w;
  logic                     win_vld;
  logic [KEY_W-1:0]         win_key;
  logic [IDX_W-1:0]         win_idx;

  mpic_regs #(.SLOT_N(SLOT_N), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mask_o(mask_w), .ctrl_o(ctrl_w)
  );

  mpic_elig #(.SLOT_N(SLOT_N), .BYTE_W(BYTE_W), .LVL_W(LVL_W), .PRI_W(PRI_W)) u_elig (
    .src(irq_src), .mask(mask_w), .ctrl(ctrl_w), .elig(elig_w), .key(key_w)
  );

  mpic_arb #(.SLOT_N(SLOT_N), .KEY_W(KEY_W)) u_arb (
    .elig(elig_w), .key(key_w),
    .win_vld(win_vld), .win_key(win_key), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '0;
      irq_vec   <= '0;
    end else begin
      irq_level <= win_vld ? win_key[KEY_W-1:PRI_W] : '0;
      irq_vec   <= win_vld ? win_idx : '0;
    end
  end

  // R3: global mask silences the outputs on the next cycle
  a_r3_mask_all_blocks: assert property (@(posedge clk) disable iff (rst)
    mask_w[0] |=> (irq_level == '0));

  // R4: slot 0 is never presented
  a_r4_slot0_never: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (irq_vec != '0));

  // R4: the arbiter never picks a masked slot
  a_r4_winner_unmasked: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> !mask_w[win_idx]);

  // R5: the winner always carries a nonzero level field
  a_r5_winner_level_set: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (win_key[KEY_W-1:PRI_W] != '0));

  // R9: idle output carries a zero vector
  a_r9_idle_zero_vec: assert property (@(posedge clk) disable iff (rst)
    (irq_level == '0) |-> (irq_vec == '0));

  // R9: no requests means idle on the next cycle
  a_r9_no_request_idle: assert property (@(posedge clk) disable iff (rst)
    (irq_src == '0) |=> (irq_level == '0));
endmodule

// File: tb/mpic_top_tb.sv
module mpic_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_src = '0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  irq_level;
  logic [5:0]  irq_vec;

  always #5 clk = ~clk;

  mpic_top u_dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .irq_vec(irq_vec)
  );

  typedef struct { logic [2:0] lvl; logic [5:0] vec; string tag; } exp_t;
  exp_t q[$];

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] m_mask;
  logic [7:0]  m_ctrl [64];

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(output logic [2:0] l, output logic [5:0] v);
    int bk;
    bk = -1; l = 0; v = 0;
    for (int i = 1; i < 64; i++) begin
      if (irq_src[i] && !m_mask[i] && !m_mask[0] && m_ctrl[i][5:3] != 0) begin
        if (int'(m_ctrl[i][5:0]) > bk) begin
          bk = int'(m_ctrl[i][5:0]);
          l = m_ctrl[i][5:3];
          v = 6'(i);
        end
      end
    end
  endfunction

  // scoreboard monitor
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() != 0) begin
      e = q.pop_front();
      chk(irq_level, e.lvl, {e.tag, " level"});
      chk(irq_vec, e.vec, {e.tag, " vec"});
    end
  end

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a[6]) m_ctrl[a[5:0]] = d;
    else m_mask[a[2:0]*8 +: 8] = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic drive(logic [63:0] v, string tag);
    exp_t e;
    @(negedge clk);
    irq_src = v;
    model(e.lvl, e.vec);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #2;
  endtask

  task automatic rd_chk(logic [6:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1;
    chk(bus_rdata, exp, tag);
  endtask

  function automatic logic [63:0] bits(int a, int b = 0, int c = 0);
    logic [63:0] r;
    r = '0;
    r[a] = 1'b1; r[b] = 1'b1; r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    m_mask = '1;
    for (int i = 0; i < 64; i++) m_ctrl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(irq_level, 0, "R2 reset level");
    chk(irq_vec, 0, "R2 reset vec");
    rd_chk(7'h00, 8'hFF, "R2 reset mask byte0");
    rd_chk(7'h07, 8'hFF, "R2 reset mask byte7");
    rd_chk(7'h45, 8'h00, "R2 reset ctrl slot5");
    drive(bits(5), "R2 masked at reset");

    for (int b = 0; b < 8; b++) wr(7'(b), 8'h00);
    rd_chk(7'h03, 8'h00, "R1 mask byte3 readback");
    drive(bits(5), "R5 unconfigured slot");
    wr(7'h45, 8'h11);
    rd_chk(7'h45, 8'h11, "R1 ctrl slot5 readback");
    drive(bits(5), "R5 slot5 lvl2");
    wr(7'h46, 8'h07);
    drive(bits(6), "R5 level-zero slot");
    drive(64'h0, "R9 idle");

    wr(7'h4A, 8'h30);
    drive(bits(5, 10), "R6 level6 beats level2");
    wr(7'h68, 8'h3F);
    drive(bits(5, 10, 40), "R6 level7 high reg");

    wr(7'h54, 8'h25);
    wr(7'h55, 8'h23);
    drive(bits(20, 21), "R7 prio5 beats prio3");
    wr(7'h55, 8'h27);
    drive(bits(20, 21), "R7 prio7 beats prio5");

    wr(7'h61, 8'h1A);
    wr(7'h72, 8'h1A);
    drive(bits(50, 33), "R8 tie lower slot");

    wr(7'h05, 8'h01);
    rd_chk(7'h05, 8'h01, "R1 mask byte5 readback");
    drive(bits(40, 10), "R4 slot40 masked");
    wr(7'h05, 8'h00);
    drive(bits(40, 10), "R4 slot40 unmasked");
    wr(7'h40, 8'h3F);
    drive(bits(0), "R4 slot0 never");

    wr(7'h00, 8'h01);
    drive(bits(40, 10, 5), "R3 mask-all set");
    wr(7'h01, 8'h00); wr(7'h02, 8'h00); wr(7'h03, 8'h00);
    drive(bits(40, 20), "R3 low reg written as 1");
    wr(7'h00, 8'h00);
    drive(bits(40, 20), "R3 mask-all cleared");

    drive(bits(21), "R9 follow change a");
    drive(bits(33), "R9 follow change b");
    drive(64'h0, "R9 back to idle");

    repeat (3) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule